// File: doc/BRIEF.md
# Multi-mode ALU instruction sequencer

This block steps an 8-bit processor through its accumulator-class ALU instructions (OR, AND, EOR, CMP, ADC, SBC) and through the compare-with-index instructions. It starts once the opcode byte has already been fetched. When `op_valid_i` is high and the block is idle, it decodes the opcode. The upper three opcode bits choose the operation. The low nibble together with bit 4 chooses one of nine addressing modes. The block then issues one memory action per cycle: an operand byte fetch at the program counter, a direct-page read, an absolute read, or an idle cycle.

In the last cycle of an instruction, the byte returned on `rdata_i` goes straight to the ALU port together with the operation code and the register that acts as the left operand. The same cycle raises `done_o` for one clock. The accumulator write strobe is raised for every operation except compare. Direct-page addresses are one byte, placed under the page byte `page_i`. Sums formed inside the direct page wrap at 8 bits. Absolute addresses plus an index form a full 16-bit sum.

The memory is expected to return read data in the same cycle as the request, so `rdata_i` is sampled at the end of each active cycle.

Top module: `alu_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `done_o`=0, `mem_kind_o`=0 (idle), `mem_addr_o`=0, `acc_we_o`=0. Bus kind codes: 0 idle, 1 fetch at PC, 2 direct-page read, 3 absolute read. `mem_addr_o` is 0 on idle and PC cycles.
- R2: The operation comes from opcode bits [7:5] and appears on `alu_op_o` as 0 OR, 1 AND, 2 EOR, 3 CMP, 4 ADC, 5 SBC. For these opcodes `alu_src_o`=0 (accumulator), and `acc_we_o` is high in the final cycle unless the operation is CMP.
- R3: Low nibble 8 with bit 4 clear is immediate mode. It takes one PC fetch, and that byte is the operand.
- R4: Low nibble 6 with bit 4 clear takes an idle cycle, then a direct-page read at {page, X}.
- R5: Low nibble 4 takes a PC fetch, then a read at {page, d}. With bit 4 set it takes a PC fetch, an idle cycle, then a read at {page, d+X}, with the sum wrapping at 8 bits.
- R6: Low nibble 5 with bit 4 clear takes a low-byte fetch, a high-byte fetch, then an absolute read. Low nibble 5 with bit 4 set (index X) and low nibble 6 with bit 4 set (index Y) add an idle cycle before reading at the 16-bit address plus the index.
- R7: Low nibble 7 with bit 4 clear takes a fetch of d, then an idle cycle. It then reads the pointer bytes at {page, d+X} and {page, d+X+1}, each sum wrapping at 8 bits, and finally reads the operand at that pointer.
- R8: Low nibble 7 with bit 4 set takes a fetch of d, then an idle cycle. It then reads the pointer bytes at {page, d} and {page, d+1}, and finally reads the operand at the pointer plus Y.
- R9: Opcodes C8, 3E and 1E compare against X (`alu_src_o`=1). Opcodes AD, 7E and 5E compare against Y (`alu_src_o`=2). The modes are immediate, direct page and absolute, in that order within each group. These opcodes never raise `acc_we_o`.
- R10: `done_o` is high only in the final cycle of an instruction, and `busy_o` is low in the cycle after it.
- R11: An opcode outside the supported set starts nothing: `busy_o` stays low and no memory action is issued.
- R12: `op_valid_i` is ignored while busy, including in the final cycle. The running sequence and its results are unchanged, and no new instruction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode offered |
| op_i | input | 8 | Opcode byte |
| x_i | input | DW | X index register |
| y_i | input | DW | Y index register |
| page_i | input | DW | Direct-page high byte |
| rdata_i | input | DW | Read data for the current cycle's request |
| mem_kind_o | output | 2 | Bus action: 0 idle, 1 PC fetch, 2 direct page, 3 absolute |
| mem_addr_o | output | 2*DW | Read address for direct-page and absolute actions |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | Final cycle of the instruction |
| alu_op_o | output | 3 | Operation code for the ALU |
| alu_src_o | output | 2 | Left operand register: 0 A, 1 X, 2 Y |
| alu_b_o | output | DW | Operand byte, valid with `done_o` |
| acc_we_o | output | 1 | Accumulator write strobe |

## Verification
Two events can land in the same cycle: the final operand read that completes an instruction, and a new opcode offered on `op_valid_i`. The bench raises `op_valid_i` with a legal opcode during a middle cycle of an absolute sequence, and again exactly in the cycle where `done_o` is high. It then checks three things: the rest of the address sequence is unchanged, the operand and operation at completion match the original instruction, and `busy_o` is low in the following cycle instead of a new instruction having started.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_PC   = 2'd1,
    BUS_DP   = 2'd2,
    BUS_ABS  = 2'd3
  } bus_kind_e;

  typedef enum logic [2:0] {
    ALU_OR  = 3'd0,
    ALU_AND = 3'd1,
    ALU_EOR = 3'd2,
    ALU_CMP = 3'd3,
    ALU_ADC = 3'd4,
    ALU_SBC = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_X = 2'd1,
    SRC_Y = 2'd2
  } src_e;

  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_XIND = 4'd1,
    M_DP   = 4'd2,
    M_DPX  = 4'd3,
    M_ABS  = 4'd4,
    M_ABSX = 4'd5,
    M_ABSY = 4'd6,
    M_DPXI = 4'd7,
    M_DPIY = 4'd8
  } mode_e;

  typedef struct packed {
    logic    ok;
    alu_op_e op;
    src_e    src;
    mode_e   mode;
  } dec_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [7:0] op_i,
  output dec_t       dec_o
);

  logic [2:0] grp;
  logic [3:0] lo;
  logic       b4;

  assign grp = op_i[7:5];
  assign lo  = op_i[3:0];
  assign b4  = op_i[4];

  always_comb begin
    dec_o      = '0;
    dec_o.src  = SRC_A;
    dec_o.mode = M_IMM;
    dec_o.op   = ALU_OR;
    dec_o.ok   = (grp <= 3'd5);
    case (grp)
      3'd0: dec_o.op = ALU_OR;
      3'd1: dec_o.op = ALU_AND;
      3'd2: dec_o.op = ALU_EOR;
      3'd3: dec_o.op = ALU_CMP;
      3'd4: dec_o.op = ALU_ADC;
      default: dec_o.op = ALU_SBC;
    endcase
    case (lo)
      4'h8: begin
        dec_o.mode = M_IMM;
        if (b4) dec_o.ok = 1'b0;
      end
      4'h6: dec_o.mode = b4 ? M_ABSY : M_XIND;
      4'h4: dec_o.mode = b4 ? M_DPX  : M_DP;
      4'h5: dec_o.mode = b4 ? M_ABSX : M_ABS;
      4'h7: dec_o.mode = b4 ? M_DPIY : M_DPXI;
      default: dec_o.ok = 1'b0;
    endcase
    // compare against an index register
    case (op_i)
      8'hC8: begin dec_o.ok = 1'b1; dec_o.op = ALU_CMP; dec_o.src = SRC_X; dec_o.mode = M_IMM; end
      8'h3E: begin dec_o.ok = 1'b1; dec_o.op = ALU_CMP; dec_o.src = SRC_X; dec_o.mode = M_DP;  end
      8'h1E: begin dec_o.ok = 1'b1; dec_o.op = ALU_CMP; dec_o.src = SRC_X; dec_o.mode = M_ABS; end
      8'hAD: begin dec_o.ok = 1'b1; dec_o.op = ALU_CMP; dec_o.src = SRC_Y; dec_o.mode = M_IMM; end
      8'h7E: begin dec_o.ok = 1'b1; dec_o.op = ALU_CMP; dec_o.src = SRC_Y; dec_o.mode = M_DP;  end
      8'h5E: begin dec_o.ok = 1'b1; dec_o.op = ALU_CMP; dec_o.src = SRC_Y; dec_o.mode = M_ABS; end
      default: ;
    endcase
  end

endmodule

// File: rtl/seq_plan.sv
module seq_plan
  import seq_pkg::*;
(
  input  mode_e             mode_i,
  input  logic [STEP_W-1:0] step_i,
  output bus_kind_e         kind_o,
  output logic              last_o
);

  logic [STEP_W-1:0] len;

  always_comb begin
    case (mode_i)
      M_IMM:          len = STEP_W'(1);
      M_XIND, M_DP:   len = STEP_W'(2);
      M_DPX, M_ABS:   len = STEP_W'(3);
      M_ABSX, M_ABSY: len = STEP_W'(4);
      default:        len = STEP_W'(5);
    endcase
  end

  always_comb begin
    case (mode_i)
      M_IMM:  kind_o = BUS_PC;
      M_XIND: kind_o = (step_i == 1) ? BUS_IDLE : BUS_DP;
      M_DP:   kind_o = (step_i == 1) ? BUS_PC : BUS_DP;
      M_DPX:  kind_o = (step_i == 1) ? BUS_PC : (step_i == 2) ? BUS_IDLE : BUS_DP;
      M_ABS:  kind_o = (step_i == 3) ? BUS_ABS : BUS_PC;
      M_ABSX, M_ABSY:
              kind_o = (step_i <= 2) ? BUS_PC : (step_i == 3) ? BUS_IDLE : BUS_ABS;
      default:
              kind_o = (step_i == 1) ? BUS_PC : (step_i == 2) ? BUS_IDLE :
                       (step_i == 5) ? BUS_ABS : BUS_DP;
    endcase
    if (step_i == '0) kind_o = BUS_IDLE;
  end

  assign last_o = (step_i != '0) && (step_i == len);

endmodule

// File: rtl/seq_addr.sv
module seq_addr
  import seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [STEP_W-1:0] step_i,
  input  bus_kind_e         kind_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  input  logic [DW-1:0]     page_i,
  output logic [2*DW-1:0]   addr_o
);

  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] ONE = 1;

  logic [DW-1:0] dp_q, plo_q, phi_q, off;
  logic [AW-1:0] ptr;
  logic          is_abs, is_ind, cap_lo, cap_hi, cap_dp;

  assign is_abs = (mode_i == M_ABS) || (mode_i == M_ABSX) || (mode_i == M_ABSY);
  assign is_ind = (mode_i == M_DPXI) || (mode_i == M_DPIY);
  assign cap_dp = (step_i == 1) && (is_ind || mode_i == M_DP || mode_i == M_DPX);
  assign cap_lo = (is_abs && step_i == 1) || (is_ind && step_i == 3);
  assign cap_hi = (is_abs && step_i == 2) || (is_ind && step_i == 4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_q  <= '0;
      plo_q <= '0;
      phi_q <= '0;
    end else begin
      // pre-indexed pointer: X is folded in at capture
      if (cap_dp) dp_q <= (mode_i == M_DPXI) ? rdata_i + x_i : rdata_i;
      if (cap_lo) plo_q <= rdata_i;
      if (cap_hi) phi_q <= rdata_i;
    end
  end

  assign ptr = {phi_q, plo_q};

  always_comb begin
    case (mode_i)
      M_XIND:         off = x_i;
      M_DPX:          off = dp_q + x_i;
      M_DPXI, M_DPIY: off = (step_i == 4) ? dp_q + ONE : dp_q;
      default:        off = dp_q;
    endcase
  end

  always_comb begin
    case (kind_i)
      BUS_DP:  addr_o = {page_i, off};
      BUS_ABS: begin
        case (mode_i)
          M_ABSX:         addr_o = ptr + {{DW{1'b0}}, x_i};
          M_ABSY, M_DPIY: addr_o = ptr + {{DW{1'b0}}, y_i};
          default:        addr_o = ptr;
        endcase
      end
      default: addr_o = '0;
    endcase
  end

  AST_PTR_HI_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == BUS_DP && is_ind && step_i == 4) |->
      (addr_o[DW-1:0] == $past(addr_o[DW-1:0]) + ONE)); // R7

  AST_DP_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == BUS_DP && mode_i == M_DPX) |-> (addr_o[AW-1:DW] == page_i)); // R5

endmodule

// File: rtl/alu_seq.sv
module alu_seq
  import seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        op_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  input  logic [DW-1:0]     page_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [1:0]        mem_kind_o,
  output logic [2*DW-1:0]   mem_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        alu_op_o,
  output logic [1:0]        alu_src_o,
  output logic [DW-1:0]     alu_b_o,
  output logic              acc_we_o
);

  dec_t              dec_new, dec_q;
  logic [STEP_W-1:0] step_q;
  bus_kind_e         kind;
  logic              last;

  seq_decode i_dec (
    .op_i  (op_i),
    .dec_o (dec_new)
  );

  seq_plan i_plan (
    .mode_i (dec_q.mode),
    .step_i (step_q),
    .kind_o (kind),
    .last_o (last)
  );

  seq_addr #(.DW(DW)) i_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (dec_q.mode),
    .step_i  (step_q),
    .kind_i  (kind),
    .rdata_i (rdata_i),
    .x_i     (x_i),
    .y_i     (y_i),
    .page_i  (page_i),
    .addr_o  (mem_addr_o)
  );

  assign busy_o = (step_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      dec_q  <= '0;
    end else if (!busy_o) begin
      if (op_valid_i && dec_new.ok) begin
        step_q <= STEP_W'(1);
        dec_q  <= dec_new;
      end
    end else if (last) begin
      step_q <= '0;
    end else begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  assign mem_kind_o = kind;
  assign done_o     = busy_o && last;
  assign alu_op_o   = dec_q.op;
  assign alu_src_o  = dec_q.src;
  assign alu_b_o    = done_o ? rdata_i : '0;
  assign acc_we_o   = done_o && (dec_q.op != ALU_CMP);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_kind_o == BUS_IDLE && !done_o && !acc_we_o)); // R1

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o)); // R10

  AST_START_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> $past(op_valid_i)); // R11

  AST_IDX_IDLE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (dec_q.mode == M_DPX || dec_q.mode == M_ABSX || dec_q.mode == M_ABSY))
      |-> ($past(mem_kind_o) == BUS_IDLE)); // R6

  AST_IDX_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> (alu_src_o == SRC_A)); // R9

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(alu_op_o) && $stable(alu_src_o))); // R12

endmodule

// File: tb/test_alu_seq.sv
`timescale 1ns/1ps
module test_alu_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op = 8'h00;
  logic [7:0]  x = 8'h00, y = 8'h00, page = 8'h01;
  logic [7:0]  rdata;
  logic [1:0]  kind;
  logic [15:0] addr;
  logic        busy, done, we;
  logic [2:0]  aop;
  logic [1:0]  src;
  logic [7:0]  b;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] prog [4];
  int pc_cnt = 0;
  int pc_base = 0;

  always #2 clk = ~clk;

  alu_seq i_alu_seq (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .x_i(x), .y_i(y), .page_i(page), .rdata_i(rdata),
    .mem_kind_o(kind), .mem_addr_o(addr), .busy_o(busy), .done_o(done),
    .alu_op_o(aop), .alu_src_o(src), .alu_b_o(b), .acc_we_o(we)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (kind == 2'd1) pc_cnt <= pc_cnt + 1;

  always @* begin
    case (kind)
      2'd1:    rdata = prog[(pc_cnt - pc_base) & 3];
      2'd2,
      2'd3:    rdata = memf(addr);
      default: rdata = 8'h00;
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input string tag, input logic [7:0] opc, input int n,
                         input logic [1:0] ek [5], input logic [15:0] ea [5],
                         input logic [7:0] eb, input logic [2:0] eop,
                         input logic [1:0] esrc, input logic ewe, input int poke);
    @(negedge clk);
    pc_base  = pc_cnt;
    op       = opc;
    op_valid = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      op_valid = (k == poke);
      op       = (k == poke) ? 8'h08 : opc;
      #1;
      chk({tag, " kind"}, kind, ek[k-1]);
      chk({tag, " addr"}, addr, ea[k-1]);
      chk({tag, " R10 busy"}, busy, 1);
      chk({tag, " R10 done"}, done, (k == n));
      if (k == n) begin
        chk({tag, " operand"}, b, eb);
        chk({tag, " R2 op"}, aop, eop);
        chk({tag, " src"}, src, esrc);
        chk({tag, " we"}, we, ewe);
      end
    end
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk({tag, " R10 idle after"}, busy, 0);
    chk({tag, " R10 no done after"}, done, 0);
    chk({tag, " R10 bus idle after"}, kind, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 busy in reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 kind", kind, 0);
    chk("R1 addr", addr, 0);
    chk("R1 we", we, 0);
  endtask

  task automatic t_imm();
    prog[0] = 8'h3C;
    run_seq("R3 OR imm", 8'h08, 1, '{1,0,0,0,0}, '{0,0,0,0,0}, 8'h3C, 3'd0, 2'd0, 1'b1, 0);
    prog[0] = 8'hC3;
    run_seq("R3 AND imm", 8'h28, 1, '{1,0,0,0,0}, '{0,0,0,0,0}, 8'hC3, 3'd1, 2'd0, 1'b1, 0);
    prog[0] = 8'h00;
    run_seq("R3 SBC imm", 8'hA8, 1, '{1,0,0,0,0}, '{0,0,0,0,0}, 8'h00, 3'd5, 2'd0, 1'b1, 0);
    prog[0] = 8'h11;
    run_seq("R2 CMP imm no write", 8'h68, 1, '{1,0,0,0,0}, '{0,0,0,0,0}, 8'h11, 3'd3, 2'd0, 1'b0, 0);
  endtask

  task automatic t_xind();
    x = 8'h77;
    run_seq("R4 ADC (X)", 8'h86, 2, '{0,2,0,0,0}, '{0,16'h0177,0,0,0},
            memf(16'h0177), 3'd4, 2'd0, 1'b1, 0);
  endtask

  task automatic t_dp();
    prog[0] = 8'h20;
    run_seq("R5 EOR dp", 8'h44, 2, '{1,2,0,0,0}, '{0,16'h0120,0,0,0},
            memf(16'h0120), 3'd2, 2'd0, 1'b1, 0);
    x = 8'hF0;
    run_seq("R5 EOR dp+X wrap", 8'h54, 3, '{1,0,2,0,0}, '{0,0,16'h0110,0,0},
            memf(16'h0110), 3'd2, 2'd0, 1'b1, 0);
  endtask

  task automatic t_abs();
    prog[0] = 8'h34; prog[1] = 8'h12;
    run_seq("R6 CMP abs", 8'h65, 3, '{1,1,3,0,0}, '{0,0,16'h1234,0,0},
            memf(16'h1234), 3'd3, 2'd0, 1'b0, 0);
    prog[0] = 8'hF8; prog[1] = 8'h12; x = 8'hF0;
    run_seq("R6 OR abs+X carry", 8'h15, 4, '{1,1,0,3,0}, '{0,0,0,16'h13E8,0},
            memf(16'h13E8), 3'd0, 2'd0, 1'b1, 0);
    y = 8'h20;
    run_seq("R6 SBC abs+Y", 8'hB6, 4, '{1,1,0,3,0}, '{0,0,0,16'h1318,0},
            memf(16'h1318), 3'd5, 2'd0, 1'b1, 0);
  endtask

  task automatic t_dpxi();
    logic [15:0] p;
    x = 8'h05; prog[0] = 8'hFD;
    p = {memf(16'h0103), memf(16'h0102)};
    run_seq("R7 AND [dp+X]", 8'h27, 5, '{1,0,2,2,3}, '{0,0,16'h0102,16'h0103,p},
            memf(p), 3'd1, 2'd0, 1'b1, 0);
    prog[0] = 8'hFA;
    p = {memf(16'h0100), memf(16'h01FF)};
    run_seq("R7 OR [dp+X] page wrap", 8'h07, 5, '{1,0,2,2,3}, '{0,0,16'h01FF,16'h0100,p},
            memf(p), 3'd0, 2'd0, 1'b1, 0);
  endtask

  task automatic t_dpiy();
    logic [15:0] p;
    y = 8'h10; prog[0] = 8'h40;
    p = {memf(16'h0141), memf(16'h0140)};
    run_seq("R8 SBC [dp]+Y", 8'hB7, 5, '{1,0,2,2,3}, '{0,0,16'h0140,16'h0141,p + 16'h0010},
            memf(p + 16'h0010), 3'd5, 2'd0, 1'b1, 0);
  endtask

  task automatic t_cmpxy();
    prog[0] = 8'h55;
    run_seq("R9 CMP X imm", 8'hC8, 1, '{1,0,0,0,0}, '{0,0,0,0,0}, 8'h55, 3'd3, 2'd1, 1'b0, 0);
    prog[0] = 8'h66;
    run_seq("R9 CMP Y imm", 8'hAD, 1, '{1,0,0,0,0}, '{0,0,0,0,0}, 8'h66, 3'd3, 2'd2, 1'b0, 0);
    prog[0] = 8'h30;
    run_seq("R9 CMP X dp", 8'h3E, 2, '{1,2,0,0,0}, '{0,16'h0130,0,0,0},
            memf(16'h0130), 3'd3, 2'd1, 1'b0, 0);
    run_seq("R9 CMP Y dp", 8'h7E, 2, '{1,2,0,0,0}, '{0,16'h0130,0,0,0},
            memf(16'h0130), 3'd3, 2'd2, 1'b0, 0);
    prog[0] = 8'h00; prog[1] = 8'h20;
    run_seq("R9 CMP X abs", 8'h1E, 3, '{1,1,3,0,0}, '{0,0,16'h2000,0,0},
            memf(16'h2000), 3'd3, 2'd1, 1'b0, 0);
    run_seq("R9 CMP Y abs", 8'h5E, 3, '{1,1,3,0,0}, '{0,0,16'h2000,0,0},
            memf(16'h2000), 3'd3, 2'd2, 1'b0, 0);
  endtask

  task automatic t_illegal();
    logic [7:0] bad [4] = '{8'hE8, 8'h0F, 8'hC4, 8'h18};
    foreach (bad[i]) begin
      @(negedge clk);
      op = bad[i];
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      #1;
      chk("R11 no start", busy, 0);
      chk("R11 no bus action", kind, 0);
      chk("R11 no done", done, 0);
    end
  endtask

  task automatic t_busy_poke();
    prog[0] = 8'h34; prog[1] = 8'h12;
    run_seq("R12 poke mid", 8'h25, 3, '{1,1,3,0,0}, '{0,0,16'h1234,0,0},
            memf(16'h1234), 3'd1, 2'd0, 1'b1, 2);
    run_seq("R12 poke on done", 8'h45, 3, '{1,1,3,0,0}, '{0,0,16'h1234,0,0},
            memf(16'h1234), 3'd2, 2'd0, 1'b1, 3);
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    prog = '{8'h00, 8'h00, 8'h00, 8'h00};
    t_reset();
    t_imm();
    t_xind();
    t_dp();
    t_abs();
    t_dpxi();
    t_dpiy();
    t_cmpxy();
    t_illegal();
    t_busy_poke();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule